// File: doc/BRIEF.md
# DMA Peripheral Request Handshake

This block sits between up to sixteen peripherals and a DMA channel engine. Each peripheral slot drives four request lines: a burst request, a final-burst request, a single-item request and a final-single request. The block registers these lines, picks one slot by fixed priority and presents the choice to the engine as a command. The command carries the slot number, whether a burst was granted, and whether the request was marked as the final one. The command stays up until the engine acknowledges it.

After the acknowledge, the block pulses a per-slot clear back to the winning peripheral. When the request was a final one, a per-slot terminal-count pulse goes out in the same cycle. A slot that has just been served is not served again until all four of its request lines have been seen low. Completion and error events set sticky per-slot status bits. Each status bit has its own interrupt enable and its own write-one-to-clear strobe. These feed a completion interrupt, an error interrupt and a combined interrupt. Everything runs on one clock.

Top module: `dma_req_handshake`

## Requirements
- R1: After reset, cmd_valid_o, clr_o, tc_o, both status vectors and all three interrupt outputs are zero.
- R2: Among eligible slots, the lowest slot index wins. cmd_valid_o rises on the second rising edge after a request is driven to an idle block, so the request is sampled first and the decision is registered.
- R3: Within one slot, a burst-kind request (burst or final-burst) outranks a single-kind request, and cmd_burst_o is 1 exactly when a burst kind was granted.
- R4: cmd_last_o is 1 when the granted kind's final line is high: the final-burst line for a burst grant, the final-single line for a single grant.
- R5: While cmd_valid_o is high and cmd_ack_i is low, the command stays up and cmd_slot_o, cmd_burst_o and cmd_last_o do not change.
- R6: One cycle after an edge where cmd_valid_o and cmd_ack_i are both high, clr_o carries a one-cycle pulse with only bit cmd_slot_o set.
- R7: tc_o pulses the served slot's bit in the same cycle as clr_o if the command was final, and stays zero otherwise.
- R8: After a slot is cleared, it is not granted again until all four of its request lines have been sampled low.
- R9: A final completion sets tc_status_o[slot] and cmd_err_i high at the acknowledge sets err_status_o[slot], both on the edge that ends the clear pulse. A 1 on tc_w1c_i[i] or err_w1c_i[i] clears that status bit.
- R10: When a status set and a write-one-to-clear hit the same bit on the same edge, the set wins and the bit reads 1.
- R11: int_tc_o is the OR of tc_status_o AND tc_ien_i, int_err_o is the OR of err_status_o AND err_ien_i, and int_o is int_tc_o OR int_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low reset |
| burst_req_i | input | NSLOT | Burst request per slot |
| burst_last_req_i | input | NSLOT | Final-burst request per slot |
| single_req_i | input | NSLOT | Single-item request per slot |
| single_last_req_i | input | NSLOT | Final-single request per slot |
| cmd_valid_o | output | 1 | Command to engine is pending |
| cmd_slot_o | output | SW | Slot number of the command |
| cmd_burst_o | output | 1 | 1 = burst, 0 = single |
| cmd_last_o | output | 1 | Command finishes the transaction |
| cmd_ack_i | input | 1 | Engine accepts the command |
| cmd_err_i | input | 1 | Engine reports an error, sampled with the acknowledge |
| clr_o | output | NSLOT | Per-slot request clear pulse |
| tc_o | output | NSLOT | Per-slot terminal-count pulse |
| tc_ien_i | input | NSLOT | Completion interrupt enables |
| err_ien_i | input | NSLOT | Error interrupt enables |
| tc_w1c_i | input | NSLOT | Completion status clear strobes |
| err_w1c_i | input | NSLOT | Error status clear strobes |
| tc_status_o | output | NSLOT | Sticky completion status |
| err_status_o | output | NSLOT | Sticky error status |
| int_tc_o | output | 1 | Completion interrupt |
| int_err_o | output | 1 | Error interrupt |
| int_o | output | 1 | Combined interrupt |

## Verification
A status bit can be set by a finishing transfer on the same edge that software strobes its write-one-to-clear. The bench provokes this in two ways. A directed case raises the clear strobe for the served slot exactly in the clear-pulse cycle. Random transfers also strobe random clear masks in that same cycle, sometimes including the served slot. A reference model applies the clear and then the set, and the bench compares both status vectors and all interrupt outputs against it after that edge.

// File: rtl/dma_req_handshake.sv
module dma_req_handshake #(
  parameter int NSLOT = 16,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] burst_req_i,
  input  logic [NSLOT-1:0] burst_last_req_i,
  input  logic [NSLOT-1:0] single_req_i,
  input  logic [NSLOT-1:0] single_last_req_i,
  output logic             cmd_valid_o,
  output logic [SW-1:0]    cmd_slot_o,
  output logic             cmd_burst_o,
  output logic             cmd_last_o,
  input  logic             cmd_ack_i,
  input  logic             cmd_err_i,
  output logic [NSLOT-1:0] clr_o,
  output logic [NSLOT-1:0] tc_o,
  input  logic [NSLOT-1:0] tc_ien_i,
  input  logic [NSLOT-1:0] err_ien_i,
  input  logic [NSLOT-1:0] tc_w1c_i,
  input  logic [NSLOT-1:0] err_w1c_i,
  output logic [NSLOT-1:0] tc_status_o,
  output logic [NSLOT-1:0] err_status_o,
  output logic             int_tc_o,
  output logic             int_err_o,
  output logic             int_o
);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_RESP} state_t;

  state_t           st;
  logic [NSLOT-1:0] rb, rbl, rs, rsl, rearm_wait;
  logic [SW-1:0]    slot_q;
  logic             burst_q, last_q, err_q;
  logic [NSLOT-1:0] tc_st, err_st;

  logic [NSLOT-1:0] want_b, want_s, served;
  logic [SW-1:0]    pick;
  logic             found;

  assign want_b = (rb | rbl) & ~rearm_wait;
  assign want_s = (rs | rsl) & ~rearm_wait;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (want_b[i] || want_s[i]) begin
        pick  = SW'(i);
        found = 1'b1;
      end
    end
  end

  assign served = NSLOT'(1) << slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb <= '0; rbl <= '0; rs <= '0; rsl <= '0;
    end else begin
      rb  <= burst_req_i;
      rbl <= burst_last_req_i;
      rs  <= single_req_i;
      rsl <= single_last_req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      slot_q  <= '0;
      burst_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (found) begin
          st      <= S_CMD;
          slot_q  <= pick;
          burst_q <= want_b[pick];
          last_q  <= want_b[pick] ? rbl[pick] : rsl[pick];
        end
        S_CMD: if (cmd_ack_i) begin
          st    <= S_RESP;
          err_q <= cmd_err_i;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rearm_wait <= '0;
    else        rearm_wait <= (rearm_wait & (rb | rbl | rs | rsl)) | clr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_st  <= '0;
      err_st <= '0;
    end else begin
      tc_st  <= (tc_st & ~tc_w1c_i)   | ((st == S_RESP && last_q) ? served : '0);
      err_st <= (err_st & ~err_w1c_i) | ((st == S_RESP && err_q)  ? served : '0);
    end
  end

  assign cmd_valid_o  = (st == S_CMD);
  assign cmd_slot_o   = slot_q;
  assign cmd_burst_o  = burst_q;
  assign cmd_last_o   = last_q;
  assign clr_o        = (st == S_RESP) ? served : '0;
  assign tc_o         = (st == S_RESP && last_q) ? served : '0;
  assign tc_status_o  = tc_st;
  assign err_status_o = err_st;
  assign int_tc_o     = |(tc_st & tc_ien_i);
  assign int_err_o    = |(err_st & err_ien_i);
  assign int_o        = int_tc_o | int_err_o;

  assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));

  assert_clr_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_ack_i |=> clr_o == (NSLOT'(1) << $past(cmd_slot_o)));

  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_slot_o)
      && $stable(cmd_burst_o) && $stable(cmd_last_o));

  assert_tc_inside_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o & ~clr_o) == '0);

  assert_tc_sets_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_o) |=> (tc_status_o & $past(tc_o)) == $past(tc_o));

  assert_no_cmd_after_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_o) |=> !cmd_valid_o);

endmodule

// File: tb/dma_req_handshake_tb.sv
module dma_req_handshake_tb;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] bq = '0, blq = '0, sq = '0, slq = '0;
  logic cmd_valid, cmd_burst, cmd_last, ack = 1'b0, err = 1'b0;
  logic [3:0] cmd_slot;
  logic [N-1:0] clr, tc, tc_ien = '0, err_ien = '0, tc_w1c = '0, err_w1c = '0;
  logic [N-1:0] tc_status, err_status;
  logic int_tc, int_err, int_any;

  int n_chk = 0, n_bad = 0;
  logic [N-1:0] exp_tc = '0, exp_err = '0;

  always #4 clk = ~clk;

  dma_req_handshake #(.NSLOT(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .burst_req_i(bq), .burst_last_req_i(blq), .single_req_i(sq), .single_last_req_i(slq),
    .cmd_valid_o(cmd_valid), .cmd_slot_o(cmd_slot), .cmd_burst_o(cmd_burst), .cmd_last_o(cmd_last),
    .cmd_ack_i(ack), .cmd_err_i(err), .clr_o(clr), .tc_o(tc),
    .tc_ien_i(tc_ien), .err_ien_i(err_ien), .tc_w1c_i(tc_w1c), .err_w1c_i(err_w1c),
    .tc_status_o(tc_status), .err_status_o(err_status),
    .int_tc_o(int_tc), .int_err_o(int_err), .int_o(int_any));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_status();
    chk("R9 tc status", 32'(tc_status), 32'(exp_tc));
    chk("R9 err status", 32'(err_status), 32'(exp_err));
    chk("R11 int_tc", 32'(int_tc), 32'(|(exp_tc & tc_ien)));
    chk("R11 int_err", 32'(int_err), 32'(|(exp_err & err_ien)));
    chk("R11 int", 32'(int_any), 32'((|(exp_tc & tc_ien)) | (|(exp_err & err_ien))));
  endtask

  function automatic void ref_pick(output int s, output logic b, output logic l);
    s = -1; b = 1'b0; l = 1'b0;
    for (int i = N - 1; i >= 0; i--)
      if (bq[i] | blq[i] | sq[i] | slq[i]) s = i;
    if (s >= 0) begin
      b = bq[s] | blq[s];
      l = b ? blq[s] : slq[s];
    end
  endfunction

  task automatic release_all();
    bq = '0; blq = '0; sq = '0; slq = '0;
  endtask

  // Requests are already driven at a negedge before the call.
  task automatic xact(input logic e, input int dly, input logic [N-1:0] tw, input logic [N-1:0] ew,
                      input logic rel, input logic lat_chk);
    int s, n;
    logic b, l;
    logic [N-1:0] oh;
    ref_pick(s, b, l);
    n = 0;
    while (!cmd_valid && n < 20) begin @(negedge clk); n++; end
    if (lat_chk) chk("R2 latency", 32'(n), 32'd2);
    chk("R2 slot", 32'(cmd_slot), 32'(s));
    chk("R3 burst", 32'(cmd_burst), 32'(b));
    chk("R4 last", 32'(cmd_last), 32'(l));
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R5 held", 32'({cmd_valid, cmd_slot, cmd_burst, cmd_last}), 32'({1'b1, 4'(s), b, l}));
    end
    ack = 1'b1; err = e;
    @(negedge clk);
    ack = 1'b0; err = 1'b0;
    oh = N'(1) << s;
    chk("R6 clr", 32'(clr), 32'(oh));
    chk("R7 tc", 32'(tc), 32'(l ? oh : '0));
    tc_w1c = tw; err_w1c = ew;
    if (rel) release_all();
    @(negedge clk);
    tc_w1c = '0; err_w1c = '0;
    exp_tc  = (exp_tc & ~tw)  | (l ? oh : '0);
    exp_err = (exp_err & ~ew) | (e ? oh : '0);
    chk("R6 clr one cycle", 32'(clr), 32'd0);
    chk_status();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #3;
    chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
    chk("R1 clr/tc", 32'({clr, tc}), 32'd0);
    chk("R1 status", 32'({tc_status, err_status}), 32'd0);
    chk("R1 ints", 32'({int_tc, int_err, int_any}), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tc_ien = '1; err_ien = '1;

    // R3: burst beats single inside the lowest slot; higher slot loses (R2)
    sq[0] = 1'b1; bq[0] = 1'b1; blq[15] = 1'b1;
    xact(1'b0, 1, '0, '0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);

    // R8: held request is not reissued until all lines drop
    slq[3] = 1'b1;
    xact(1'b1, 0, '0, '0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R8 no reissue while held", 32'(cmd_valid), 32'd0);
      @(negedge clk);
    end
    slq[3] = 1'b0;
    @(negedge clk);
    sq[3] = 1'b1;
    xact(1'b0, 0, '0, '0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);

    // R10: set and clear on the same edge: set wins
    blq[5] = 1'b1;
    xact(1'b1, 2, N'(1) << 5, N'(1) << 5, 1'b1, 1'b1);
    chk("R10 tc set wins", 32'(tc_status[5]), 32'd1);
    chk("R10 err set wins", 32'(err_status[5]), 32'd1);
    repeat (2) @(negedge clk);

    // R9: plain write-one-to-clear
    tc_w1c = '1; err_w1c = '1;
    @(negedge clk);
    tc_w1c = '0; err_w1c = '0;
    exp_tc = '0; exp_err = '0;
    chk_status();

    // Random traffic
    for (int it = 0; it < 80; it++) begin
      tc_ien = N'($urandom); err_ien = N'($urandom);
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(3) == 0) begin
          bq[i] = $urandom_range(1); blq[i] = $urandom_range(1);
          sq[i] = $urandom_range(1); slq[i] = $urandom_range(1);
        end
      end
      if ((bq | blq | sq | slq) == '0) sq[$urandom_range(N-1)] = 1'b1;
      xact(1'($urandom_range(1)), $urandom_range(3), N'($urandom), N'($urandom), 1'b1, 1'b1);
      repeat (2) @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule